// File: doc/BRIEF.md
# Host Interface Interrupt Status Register

This block holds the eight-bit status byte that a local controller reads to follow what the host side of a storage drive is doing. Each bit has its own set event and its own clear event. Set events come from host register writes, the sector decoder, the subcode path and transfer control. Clear events come from the local CPU reading or writing particular registers. The block also produces one combined interrupt line for the local CPU.

The block has two modes, chosen by `atapi_mode`. In packet-command (ATAPI) mode, bit 7 latches host command writes and bit 2 latches a host soft-reset request. The soft-reset bit can never be masked from the interrupt line, and bits 1 and 0 read as zero. In legacy compatibility mode, bit 7 shows the command-input FIFO level directly. Bit 2 then tracks a status-byte transfer, and bits 1 and 0 hold the two transfer-enable pins, sampled when a host access ends.

The FIFOs, the decoder and the bus timing lie outside this block. It sees them only as strobes and levels. A strobe that is high at a rising clock edge shows in `status` after that edge.

Top module: `hif_irq_status`

## Requirements
- R1: After reset all latched bits are 0, so `status` reads 8'h00 and `irq` is 0 while `cmdfifo_nonempty` is low.
- R2: In ATAPI mode, bit 7 sets on `host_cmd_wr` when `drv_sel` is high, or when `host_cmd_code` is 8'h90 whatever the value of `drv_sel`. It clears on `cmd_reg_rd`.
- R3: In compatibility mode, bit 7 equals `cmdfifo_nonempty` in the same cycle, with no register in the path.
- R4: Bit 6 sets on `xfer_end` and clears on `xfer_ack_wr`. `prog_cmd_rx` and `mem_xfer_done` also set it, but only in ATAPI mode; in compatibility mode they have no effect.
- R5: Bit 5 sets on `sector_new` and clears on `dec_stat_rd`. Bit 4 sets on `subcode_new` and clears on `subcode_rd`.
- R6: Bit 3 sets on `xfer_trig_wr` and clears on `xfer_end`.
- R7: In ATAPI mode, bit 2 sets on `host_devctl_wr` with `host_srst_bit` high and clears on `devctl_rd`. A control write with `host_srst_bit` low leaves it unchanged. While bit 2 is set, `irq` is high whatever `irq_en` holds.
- R8: In compatibility mode, bit 2 sets on `stat_out_wr` and clears on `stat_drained`.
- R9: In compatibility mode, bit 1 takes `dten_pin` and bit 0 takes `sten_pin`, only in a cycle with `host_access_end`; otherwise they hold. In ATAPI mode, bits 1:0 read 0.
- R10: When a set event and a clear event for the same bit arrive in one cycle, the bit ends up set.
- R11: `irq` is the OR of `status[7:4] & irq_en`, where `irq_en[3]` enables bit 7 and `irq_en[0]` enables bit 4, ORed with the latched soft-reset bit in ATAPI mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| atapi_mode | input | 1 | 1 = ATAPI mode, 0 = compatibility mode |
| host_cmd_wr | input | 1 | Host wrote the command register |
| host_cmd_code | input | 8 | Byte written by the host |
| drv_sel | input | 1 | This drive is selected |
| cmd_reg_rd | input | 1 | Local read of the command register |
| cmdfifo_nonempty | input | 1 | Command-input FIFO holds bytes |
| xfer_end | input | 1 | Data transfer finished |
| xfer_ack_wr | input | 1 | Local write of the transfer-acknowledge register |
| prog_cmd_rx | input | 1 | Program command received (ATAPI) |
| mem_xfer_done | input | 1 | Local memory transfer finished (ATAPI) |
| sector_new | input | 1 | New sector available |
| dec_stat_rd | input | 1 | Local read of the decoder status register |
| subcode_new | input | 1 | New subcode available |
| subcode_rd | input | 1 | Local read of the subcode register |
| xfer_trig_wr | input | 1 | Local write of the transfer-trigger register |
| host_devctl_wr | input | 1 | Host wrote the device control register |
| host_srst_bit | input | 1 | Soft-reset bit of that write |
| devctl_rd | input | 1 | Local read of the device control register |
| stat_out_wr | input | 1 | Local write of the status-out register |
| stat_drained | input | 1 | Host emptied the status FIFO |
| host_access_end | input | 1 | A host read or write has ended |
| dten_pin | input | 1 | Data-transfer-enable pin level |
| sten_pin | input | 1 | Status-transfer-enable pin level |
| irq_en | input | 4 | Enables for bits 7..4 (MSB = bit 7) |
| status | output | 8 | Status byte |
| irq | output | 1 | Combined interrupt to the local CPU |

## Verification
The bench runs every combination of the four enables against every pattern of the four maskable flags. A design with a shifted enable mapping, or one that ANDs instead of ORs, would show a wrong `irq` in one of those 256 cases.

The diagnostic-code test sweeps both selection states against the 0x90 code and a plain command code. A design that ignores the code, or ignores selection, would set bit 7 in a case where it must stay clear, or miss it in a case where it must set.

Other tests pulse set and clear events together. A design where clear wins would lose an event. Further tests move the pins without an access end, send ATAPI-only events in compatibility mode, and make a control write with the soft-reset bit low. A design that samples the pins continuously or fails to gate by mode would change a bit that must hold.

A soft-reset request with all enables off checks that this bit cannot be masked from `irq`.

// File: rtl/hif_irq_status.sv
module hif_irq_status #(
  parameter logic [7:0] DIAG_CODE = 8'h90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       atapi_mode,
  input  logic       host_cmd_wr,
  input  logic [7:0] host_cmd_code,
  input  logic       drv_sel,
  input  logic       cmd_reg_rd,
  input  logic       cmdfifo_nonempty,
  input  logic       xfer_end,
  input  logic       xfer_ack_wr,
  input  logic       prog_cmd_rx,
  input  logic       mem_xfer_done,
  input  logic       sector_new,
  input  logic       dec_stat_rd,
  input  logic       subcode_new,
  input  logic       subcode_rd,
  input  logic       xfer_trig_wr,
  input  logic       host_devctl_wr,
  input  logic       host_srst_bit,
  input  logic       devctl_rd,
  input  logic       stat_out_wr,
  input  logic       stat_drained,
  input  logic       host_access_end,
  input  logic       dten_pin,
  input  logic       sten_pin,
  input  logic [3:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);

  logic cmd_q, te_q, sec_q, sub_q, busy_q, srst_q, stb_q;
  logic [1:0] pin_q;

  wire cmd_set  = atapi_mode && host_cmd_wr && (drv_sel || host_cmd_code == DIAG_CODE);
  wire te_set   = xfer_end || (atapi_mode && (prog_cmd_rx || mem_xfer_done));
  wire srst_set = atapi_mode && host_devctl_wr && host_srst_bit;
  wire stb_set  = !atapi_mode && stat_out_wr;

  // set terms are ORed after the clear terms: a simultaneous set wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      te_q   <= 1'b0;
      sec_q  <= 1'b0;
      sub_q  <= 1'b0;
      busy_q <= 1'b0;
      srst_q <= 1'b0;
      stb_q  <= 1'b0;
      pin_q  <= 2'b00;
    end else begin
      cmd_q  <= cmd_set      | (cmd_q  & ~cmd_reg_rd);
      te_q   <= te_set       | (te_q   & ~xfer_ack_wr);
      sec_q  <= sector_new   | (sec_q  & ~dec_stat_rd);
      sub_q  <= subcode_new  | (sub_q  & ~subcode_rd);
      busy_q <= xfer_trig_wr | (busy_q & ~xfer_end);
      srst_q <= srst_set     | (srst_q & ~devctl_rd);
      stb_q  <= stb_set      | (stb_q  & ~stat_drained);
      if (host_access_end) pin_q <= {dten_pin, sten_pin};
    end
  end

  assign status = atapi_mode
    ? {cmd_q, te_q, sec_q, sub_q, busy_q, srst_q, 2'b00}
    : {cmdfifo_nonempty, te_q, sec_q, sub_q, busy_q, stb_q, pin_q};

  assign irq = (|(status[7:4] & irq_en)) | (atapi_mode & srst_q);

  p_diag_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (atapi_mode && host_cmd_wr && host_cmd_code == DIAG_CODE)
      |=> (!atapi_mode || status[7]));

  p_xfer_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> status[6]);

  p_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_new && dec_stat_rd) |=> status[5]);

  p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_trig_wr |=> status[3]);

  p_srst_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (atapi_mode && status[2]) |-> irq);

  p_pin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!atapi_mode && !host_access_end) |=> (atapi_mode || $stable(status[1:0])));

endmodule

// File: tb/hif_irq_status_bench.sv
`timescale 1ns/1ps
module hif_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic atapi_mode = 1'b1;
  logic host_cmd_wr = 0, drv_sel = 0, cmd_reg_rd = 0, cmdfifo_nonempty = 0;
  logic [7:0] host_cmd_code = 8'h00;
  logic xfer_end = 0, xfer_ack_wr = 0, prog_cmd_rx = 0, mem_xfer_done = 0;
  logic sector_new = 0, dec_stat_rd = 0, subcode_new = 0, subcode_rd = 0;
  logic xfer_trig_wr = 0, host_devctl_wr = 0, host_srst_bit = 0, devctl_rd = 0;
  logic stat_out_wr = 0, stat_drained = 0, host_access_end = 0;
  logic dten_pin = 0, sten_pin = 0;
  logic [3:0] irq_en = 4'h0;
  logic [7:0] status;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hif_irq_status u_hif_irq_status (
    .clk(clk), .rst_n(rst_n), .atapi_mode(atapi_mode),
    .host_cmd_wr(host_cmd_wr), .host_cmd_code(host_cmd_code), .drv_sel(drv_sel),
    .cmd_reg_rd(cmd_reg_rd), .cmdfifo_nonempty(cmdfifo_nonempty),
    .xfer_end(xfer_end), .xfer_ack_wr(xfer_ack_wr), .prog_cmd_rx(prog_cmd_rx),
    .mem_xfer_done(mem_xfer_done), .sector_new(sector_new), .dec_stat_rd(dec_stat_rd),
    .subcode_new(subcode_new), .subcode_rd(subcode_rd), .xfer_trig_wr(xfer_trig_wr),
    .host_devctl_wr(host_devctl_wr), .host_srst_bit(host_srst_bit), .devctl_rd(devctl_rd),
    .stat_out_wr(stat_out_wr), .stat_drained(stat_drained),
    .host_access_end(host_access_end), .dten_pin(dten_pin), .sten_pin(sten_pin),
    .irq_en(irq_en), .status(status), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    host_cmd_wr = 0; cmd_reg_rd = 0; xfer_end = 0; xfer_ack_wr = 0;
    prog_cmd_rx = 0; mem_xfer_done = 0; sector_new = 0; dec_stat_rd = 0;
    subcode_new = 0; subcode_rd = 0; xfer_trig_wr = 0; host_devctl_wr = 0;
    host_srst_bit = 0; devctl_rd = 0; stat_out_wr = 0; stat_drained = 0;
    host_access_end = 0;
  endtask

  task automatic clear_all();
    cmd_reg_rd = 1; xfer_ack_wr = 1; dec_stat_rd = 1; subcode_rd = 1;
    devctl_rd = 1; stat_drained = 1;
    tick(); idle();
    if (status[3]) begin xfer_end = 1; tick(); idle(); xfer_ack_wr = 1; tick(); idle(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    tick();
    chk("R1 after release", status, 8'h00);

    // R2: selection x code sweep
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 2; c++) begin
        clear_all();
        drv_sel = s[0]; host_cmd_code = c[0] ? 8'h90 : 8'hA0; host_cmd_wr = 1;
        tick(); idle();
        chk("R2 cmd set", {7'b0, status[7]}, {7'b0, (s[0] | c[0])});
        cmd_reg_rd = 1; tick(); idle();
        chk("R2 cmd clear", {7'b0, status[7]}, 8'h00);
      end
    end
    drv_sel = 0;

    // R11: enable x flag sweep
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        clear_all();
        irq_en = m[3:0];
        drv_sel = 1; host_cmd_wr = p[3];
        xfer_end = p[2]; sector_new = p[1]; subcode_new = p[0];
        tick(); idle();
        if (status[3]) begin end
        chk("R11 flags", {4'b0, status[7:4]}, {4'b0, p[3:0]});
        chk("R11 irq", {7'b0, irq}, {7'b0, |(m[3:0] & p[3:0])});
      end
    end
    drv_sel = 0; irq_en = 4'h0;

    // R4 ATAPI-only sources
    clear_all();
    prog_cmd_rx = 1; tick(); idle();
    chk("R4 prog cmd atapi", {7'b0, status[6]}, 8'h01);
    xfer_ack_wr = 1; tick(); idle();
    chk("R4 ack clear", {7'b0, status[6]}, 8'h00);
    mem_xfer_done = 1; tick(); idle();
    chk("R4 mem xfer atapi", {7'b0, status[6]}, 8'h01);

    // R5 subcode clear, R10 set wins
    clear_all();
    subcode_new = 1; tick(); idle();
    subcode_rd = 1; tick(); idle();
    chk("R5 subcode clear", {7'b0, status[4]}, 8'h00);
    sector_new = 1; dec_stat_rd = 1; tick(); idle();
    chk("R10 sector set wins", {7'b0, status[5]}, 8'h01);
    xfer_end = 1; xfer_ack_wr = 1; tick(); idle();
    chk("R10 xfer end wins", {7'b0, status[6]}, 8'h01);

    // R6 busy
    clear_all();
    xfer_trig_wr = 1; tick(); idle();
    chk("R6 busy set", {7'b0, status[3]}, 8'h01);
    xfer_trig_wr = 1; xfer_end = 1; tick(); idle();
    chk("R10 busy set wins", {7'b0, status[3]}, 8'h01);
    xfer_end = 1; tick(); idle();
    chk("R6 busy clear", {7'b0, status[3]}, 8'h00);

    // R7 soft reset
    clear_all();
    irq_en = 4'h0;
    host_devctl_wr = 1; host_srst_bit = 0; tick(); idle();
    chk("R7 no srst bit", {7'b0, status[2]}, 8'h00);
    host_devctl_wr = 1; host_srst_bit = 1; tick(); idle();
    chk("R7 srst set", {7'b0, status[2]}, 8'h01);
    chk("R7 irq unmasked", {7'b0, irq}, 8'h01);
    chk("R9 atapi pins zero", {6'b0, status[1:0]}, 8'h00);
    devctl_rd = 1; tick(); idle();
    chk("R7 srst clear", {7'b0, status[2]}, 8'h00);
    chk("R7 irq low", {7'b0, irq}, 8'h00);

    // compatibility mode
    atapi_mode = 0;
    clear_all();
    cmdfifo_nonempty = 1; #1;
    chk("R3 fifo high", {7'b0, status[7]}, 8'h01);
    cmdfifo_nonempty = 0; #1;
    chk("R3 fifo low", {7'b0, status[7]}, 8'h00);
    @(negedge clk);
    host_cmd_wr = 1; drv_sel = 1; tick(); idle();
    chk("R3 cmd write ignored", {7'b0, status[7]}, 8'h00);
    drv_sel = 0;
    prog_cmd_rx = 1; mem_xfer_done = 1; tick(); idle();
    chk("R4 compat ignored", {7'b0, status[6]}, 8'h00);
    host_devctl_wr = 1; host_srst_bit = 1; tick(); idle();
    chk("R8 srst ignored", {7'b0, status[2]}, 8'h00);
    stat_out_wr = 1; tick(); idle();
    chk("R8 stat busy set", {7'b0, status[2]}, 8'h01);
    stat_drained = 1; tick(); idle();
    chk("R8 stat busy clear", {7'b0, status[2]}, 8'h00);
    stat_out_wr = 1; stat_drained = 1; tick(); idle();
    chk("R10 stat busy wins", {7'b0, status[2]}, 8'h01);
    clear_all();

    // R9 pins
    for (int v = 0; v < 4; v++) begin
      logic [1:0] prev;
      prev = status[1:0];
      dten_pin = v[1]; sten_pin = v[0]; tick();
      chk("R9 pins hold", {6'b0, status[1:0]}, {6'b0, prev});
      host_access_end = 1; tick(); idle();
      chk("R9 pins capture", {6'b0, status[1:0]}, {6'b0, v[1:0]});
      dten_pin = ~v[1]; sten_pin = ~v[0]; tick();
      chk("R9 pins hold after", {6'b0, status[1:0]}, {6'b0, v[1:0]});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule